// File: doc/BRIEF.md
# Quad-Rate Four-Beat Burst SRAM Core

This block models a synchronous static memory with two fully independent data paths: a write-only input data bus and a read-only output data bus. The two buses never share wires, so no turnaround cycle is ever needed. A single address bus is time-shared between the two paths. The block runs from one core clock at twice the rate of the notional K clock. An internal phase bit splits the core edges into alternating K slots and K-bar slots. A read address is taken in a K slot and a write address in a K-bar slot. Each port starts an access only when its own active-low select is asserted. The phase is brought out so that the host can align itself to the slots.

Every address selects a group of four consecutive words, and every access is a four-beat burst with one word per core edge. That is two words per K cycle, which gives double data rate. Write data and a per-lane byte enable are sampled on the edge that takes the write address and on the three edges after it. The block sequences and commits the words itself, with no write-pulse timing from the host. Read data leaves through an output register exactly four core edges (2.0 K cycles) after the read address is taken, and a read-valid output marks the four beats.

There is no back-pressure on either path. Neither port has a ready signal, and the host must honour the fixed slot and burst timing. A new burst on a port is accepted at most every second slot of that port's kind. Bursts placed at that pace stream without gaps.

Top module: `quad_burst_sram`

## Requirements
- R1: After reset `rvalid` is low and `slot_kbar` is 0. From then on `slot_kbar` inverts on every core clock edge. A rising edge taken while `slot_kbar` is 0 is a K slot, and one taken while it is 1 is a K-bar slot.
- R2: A read starts only when `rd_sel_n` is low at a K-slot edge. Holding `rd_sel_n` low at a K-bar-slot edge starts nothing, and `rvalid` stays low.
- R3: A write starts only when `wr_sel_n` is low at a K-bar-slot edge. Holding `wr_sel_n` low at a K-slot edge leaves the memory unchanged.
- R4: For a read taken at edge E with group address A, word 4*A+k appears on `rdata` with `rvalid` high during the core cycle that follows edge E+4+k, for k = 0..3. `rvalid` is high for those four cycles only, unless the next burst follows straight on.
- R5: For a write taken at edge W with group address A, the values of `wdata` and `wbe` sampled at edge W+k are written to word 4*A+k, for k = 0..3.
- R6: Byte lane j of a word is bits 9*j+8 down to 9*j. A lane whose `wbe[j]` bit is 0 in a beat keeps its previous contents.
- R7: Once a read is accepted, a read request in the next K slot is ignored. Once a write is accepted, a write request in the next K-bar slot is ignored, and the earlier write's remaining beats still complete.
- R8: Reads accepted in every second K slot produce one unbroken stream of beats, with `rvalid` continuously high and no earlier burst disturbed.
- R9: A read returns the newest data. It reflects every write burst taken in a K-bar slot before its own K slot, including one whose data beats are still arriving, and also the write taken in the K-bar slot directly after it. Writes taken later do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock at twice the K rate, rising edge only |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_kbar | output | 1 | Phase: 0 means the next edge is a K slot, 1 means a K-bar slot |
| addr | input | ADDR_W | Shared group address: the read address in K slots, the write address in K-bar slots |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| wdata | input | WORD_W | Write data word, one per core edge during a write burst |
| wbe | input | WORD_W/9 | Active-high byte-lane enables, sampled with each write word |
| rdata | output | WORD_W | Registered read data word |
| rvalid | output | 1 | High during the four output beats of a read burst |

## Verification
A read taken at the sampling edge that the bench drives before is due on the output in the cycle after the fourth following edge. Its remaining beats follow on the next three edges. The driver therefore queues each expected word tagged with its due cycle number, which is the drive cycle plus five plus the beat index. The monitor samples on the falling edge and compares only when the cycle counter equals the head entry's due cycle. A beat that arrives early, arrives late, or is never expected is reported either as a mismatch or as an unexpected `rvalid`. Write effects, ignored requests and coherency are judged solely through these timed reads, against a reference memory that the driver updates in slot order.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
  localparam int LANE_W    = 9;
  localparam int BURST     = 4;
  localparam int BEAT_W    = $clog2(BURST);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST - 1);
endpackage

// File: rtl/qbs_in_reg.sv
module qbs_in_reg
  import qbs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  wbe,
  output logic              ph,
  output logic              q_rd,
  output logic              q_wr,
  output logic [ADDR_W-1:0] q_addr,
  output logic [WORD_W-1:0] q_wdata,
  output logic [LANES-1:0]  q_wbe
);

  // Phase 0: the coming edge is a K slot (read address).
  // Phase 1: the coming edge is a K-bar slot (write address).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= 1'b0;
      q_rd    <= 1'b0;
      q_wr    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      q_wbe   <= '0;
    end else begin
      ph      <= ~ph;
      q_rd    <= ~rd_sel_n & ~ph;
      q_wr    <= ~wr_sel_n &  ph;
      q_addr  <= addr;
      q_wdata <= wdata;
      q_wbe   <= wbe;
    end
  end

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ph != $past(ph))); // R1

endmodule

// File: rtl/qbs_rd_seq.sv
module qbs_rd_seq
  import qbs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [ADDR_W-1:0]        req_addr,
  output logic                     iss_v,
  output logic [ADDR_W+BEAT_W-1:0] iss_addr
);

  logic [1:0]        hist;   // accepts one and two cycles back
  logic              acc;
  logic              cmd_v;
  logic [ADDR_W-1:0] cmd_a;
  logic              act;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;

  // A request in the slot right after an accepted one is dropped.
  assign acc = req & ~hist[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      cmd_v <= 1'b0;
      cmd_a <= '0;
    end else begin
      hist  <= {hist[0], acc};
      cmd_v <= acc;
      cmd_a <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      beat <= '0;
      base <= '0;
    end else if (cmd_v) begin
      act  <= 1'b1;
      beat <= '0;
      base <= cmd_a;
    end else if (act) begin
      if (beat == LAST_BEAT) act <= 1'b0;
      beat <= beat + 1'b1;
    end
  end

  assign iss_v    = act;
  assign iss_addr = {base, beat};

  AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |-> !$past(cmd_v, 2)); // R7

  AST_RD_SEAMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v |-> (!act || beat == LAST_BEAT)); // R8

endmodule

// File: rtl/qbs_wr_seq.sv
module qbs_wr_seq
  import qbs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [WORD_W-1:0]        beat_data,
  input  logic [LANES-1:0]         beat_be,
  output logic                     we,
  output logic [ADDR_W+BEAT_W-1:0] waddr,
  output logic [WORD_W-1:0]        wdata,
  output logic [LANES-1:0]         wbe
);

  logic [1:0]        hist;
  logic              acc;
  logic              act;
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] base;

  assign acc = req & ~hist[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      act  <= 1'b0;
      beat <= '0;
      base <= '0;
    end else begin
      hist <= {hist[0], acc};
      if (acc) begin
        act  <= 1'b1;
        beat <= BEAT_W'(1);
        base <= req_addr;
      end else if (act) begin
        if (beat == LAST_BEAT) act <= 1'b0;
        beat <= beat + 1'b1;
      end
    end
  end

  // Beat 0 commits on the edge after the address edge; later beats follow.
  always_comb begin
    we    = acc | act;
    waddr = acc ? {req_addr, {BEAT_W{1'b0}}} : {base, beat};
    wdata = beat_data;
    wbe   = beat_be;
  end

  AST_WR_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> !act); // R7

endmodule

// File: rtl/qbs_array.sv
module qbs_array
  import qbs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W+BEAT_W-1:0] waddr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [LANES-1:0]         wbe,
  input  logic                     re,
  input  logic [ADDR_W+BEAT_W-1:0] raddr,
  output logic [WORD_W-1:0]        rdata,
  output logic                     rvalid
);

  localparam int WA_W  = ADDR_W + BEAT_W;
  localparam int DEPTH = 1 << WA_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] rd_lane;

    always_ff @(posedge clk) begin
      if (we && wbe[l]) cells[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (re) rd_lane <= cells[raddr];
    end

    assign rdata[l*LANE_W +: LANE_W] = rd_lane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end

  AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(waddr)); // R5

endmodule

// File: rtl/quad_burst_sram.sv
module quad_burst_sram
  import qbs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     slot_kbar,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd_sel_n,
  input  logic                     wr_sel_n,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [WORD_W/LANE_W-1:0] wbe,
  output logic [WORD_W-1:0]        rdata,
  output logic                     rvalid
);

  localparam int LANES = WORD_W / LANE_W;
  localparam int WA_W  = ADDR_W + BEAT_W;

  logic              q_rd, q_wr;
  logic [ADDR_W-1:0] q_addr;
  logic [WORD_W-1:0] q_wdata;
  logic [LANES-1:0]  q_wbe;

  logic              iss_v;
  logic [WA_W-1:0]   iss_addr;

  logic              a_we;
  logic [WA_W-1:0]   a_waddr;
  logic [WORD_W-1:0] a_wdata;
  logic [LANES-1:0]  a_wbe;

  logic [WORD_W-1:0] arr_d;
  logic              arr_v;

  qbs_in_reg #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_in (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .wdata(wdata), .wbe(wbe), .ph(slot_kbar),
    .q_rd(q_rd), .q_wr(q_wr), .q_addr(q_addr), .q_wdata(q_wdata),
    .q_wbe(q_wbe)
  );

  qbs_rd_seq #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .req(q_rd), .req_addr(q_addr),
    .iss_v(iss_v), .iss_addr(iss_addr)
  );

  qbs_wr_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .req(q_wr), .req_addr(q_addr),
    .beat_data(q_wdata), .beat_be(q_wbe), .we(a_we), .waddr(a_waddr),
    .wdata(a_wdata), .wbe(a_wbe)
  );

  qbs_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANES(LANES)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(a_we), .waddr(a_waddr), .wdata(a_wdata),
    .wbe(a_wbe), .re(iss_v), .raddr(iss_addr), .rdata(arr_d),
    .rvalid(arr_v)
  );

  // Output register stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= arr_v ? arr_d : '0;
      rvalid <= arr_v;
    end
  end

  AST_BURST_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvalid) |-> $past(rvalid, 4)); // R4

endmodule

// File: tb/quad_burst_sram_test.sv
module quad_burst_sram_test;
  localparam int AW = 4;
  localparam int WW = 18;
  localparam int BW = 2;
  localparam int NG = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          slot_kbar;
  logic [AW-1:0] addr = '0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [WW-1:0] wdata = '0;
  logic [BW-1:0] wbe = '0;
  logic [WW-1:0] rdata;
  logic          rvalid;

  quad_burst_sram #(.ADDR_W(AW), .WORD_W(WW)) uut (
    .clk(clk), .rst_n(rst_n), .slot_kbar(slot_kbar), .addr(addr),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .wdata(wdata), .wbe(wbe),
    .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0;
  int errors = 0;
  int unsigned cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [WW-1:0] ref_m [NG*4];
  int unsigned   q_due[$];
  logic [WW-1:0] q_dat[$];
  string         q_tag[$];
  logic [WW-1:0] pd[$];
  logic [BW-1:0] pb[$];
  bit prev_rd = 0;
  bit prev_wr = 0;

  // Monitor: compares beats in their due cycle.
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        checks++;
        if (!rvalid || rdata !== q_dat[0]) begin
          errors++;
          $display("FAIL %s: rvalid=%b rdata=%h expected rvalid=1 rdata=%h",
                   q_tag[0], rvalid, rdata, q_dat[0]);
        end
        void'(q_due.pop_front());
        void'(q_dat.pop_front());
        void'(q_tag.pop_front());
      end else if (rvalid) begin
        checks++;
        errors++;
        $display("FAIL R2/R4/R7 unexpected beat: rvalid=%b rdata=%h expected rvalid=0",
                 rvalid, rdata);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pat(int g, int k, int s);
    return WW'((s * 1237 + g * 97 + k * 29 + 5) ^ (s << 9));
  endfunction

  task automatic drive_beat();
    if (pd.size() > 0) begin
      wdata = pd.pop_front();
      wbe   = pb.pop_front();
    end else begin
      wdata = '1;
      wbe   = '1;
    end
  endtask

  // One K cycle: K slot (read address) then K-bar slot (write address).
  task automatic op(bit rd, int ra, bit wr, int wa, int salt,
                    logic [BW-1:0] be, string tag);
    bit ra_ok;
    bit wa_ok;
    logic [WW-1:0] d;
    ra_ok = rd && !prev_rd;
    wa_ok = wr && !prev_wr;
    // A write in the K-bar slot of this K cycle is visible to this read (R9).
    if (wa_ok)
      for (int k = 0; k < 4; k++) begin
        d = pat(wa, k, salt);
        for (int j = 0; j < BW; j++)
          if (be[j]) ref_m[wa*4+k][j*9 +: 9] = d[j*9 +: 9];
      end
    if (ra_ok)
      for (int k = 0; k < 4; k++) begin
        q_due.push_back(cyc + 5 + k);
        q_dat.push_back(ref_m[ra*4+k]);
        q_tag.push_back(tag);
      end
    addr = AW'(ra); rd_sel_n = !rd; wr_sel_n = 1'b1;
    drive_beat();
    @(negedge clk);
    addr = AW'(wa); rd_sel_n = 1'b1; wr_sel_n = !wr;
    if (wa_ok)
      for (int k = 0; k < 4; k++) begin
        pd.push_back(pat(wa, k, salt));
        pb.push_back(be);
      end
    drive_beat();
    @(negedge clk);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    prev_rd = ra_ok;
    prev_wr = wa_ok;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 0, '0, "idle");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [15:0] lf;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and phase alternation
    chk(rvalid == 1'b0, "R1 rvalid after reset", int'(rvalid), 0);
    chk(slot_kbar == 1'b0, "R1 slot_kbar after reset", int'(slot_kbar), 0);
    @(negedge clk);
    chk(slot_kbar == 1'b1, "R1 slot_kbar toggles", int'(slot_kbar), 1);
    @(negedge clk);
    chk(slot_kbar == 1'b0, "R1 slot_kbar toggles back", int'(slot_kbar), 0);

    // R5 fill every group, full lanes
    for (int g = 0; g < NG; g++) begin
      op(0, 0, 1, g, 1, '1, "R5");
      idle(1);
    end
    idle(2);

    // R4 single reads, R8 back-to-back stream
    op(1, 2, 0, 0, 0, '0, "R4 read g2");
    idle(4);
    op(1, 5, 0, 0, 0, '0, "R8 stream a");
    idle(1);
    op(1, 6, 0, 0, 0, '0, "R8 stream b");
    idle(1);
    op(1, 7, 0, 0, 0, '0, "R8 stream c");
    idle(4);

    // R6 partial byte enables
    op(0, 0, 1, 3, 2, 2'b01, "R6");
    idle(1);
    op(0, 0, 1, 4, 3, 2'b10, "R6");
    idle(2);
    op(1, 3, 0, 0, 0, '0, "R6 lane0 only");
    idle(1);
    op(1, 4, 0, 0, 0, '0, "R6 lane1 only");
    idle(4);

    // R7 dropped read and dropped write
    op(1, 8, 0, 0, 0, '0, "R7 first read");
    op(1, 9, 0, 0, 0, '0, "R7 second read");
    idle(4);
    op(0, 0, 1, 10, 4, '1, "R7");
    op(0, 0, 1, 11, 5, '1, "R7");
    idle(2);
    op(1, 11, 0, 0, 0, '0, "R7 ignored write g11");
    idle(1);
    op(1, 10, 0, 0, 0, '0, "R7 accepted write g10");
    idle(4);

    // R9 coherency
    op(1, 12, 1, 12, 6, '1, "R9 same K cycle write");
    idle(1);
    op(0, 0, 1, 13, 7, '1, "R9");
    op(1, 13, 0, 0, 0, '0, "R9 pending write");
    idle(1);
    op(1, 14, 0, 0, 0, '0, "R9 later write not seen");
    op(0, 0, 1, 14, 8, '1, "R9");
    idle(2);
    op(1, 14, 0, 0, 0, '0, "R9 later write now seen");
    idle(4);

    // R2/R3 selects in the wrong slot
    addr = AW'(9); rd_sel_n = 1'b1; wr_sel_n = 1'b0; wdata = '0; wbe = '1;
    @(negedge clk);
    addr = AW'(9); rd_sel_n = 1'b0; wr_sel_n = 1'b1;
    @(negedge clk);
    rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    prev_rd = 0; prev_wr = 0;
    for (int i = 0; i < 8; i++) begin
      chk(rvalid == 1'b0, "R2 read in K-bar slot", int'(rvalid), 0);
      @(negedge clk);
    end
    op(1, 9, 0, 0, 0, '0, "R3 write in K slot ignored");
    idle(4);

    // Mixed concurrent traffic
    lf = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      op(lf[0], int'(lf[5:2]), lf[1], int'(lf[9:6]), 20 + i, lf[11:10],
         "R9 mixed traffic");
      for (int s = 0; s < 3; s++)
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    idle(6);
    chk(q_due.size() == 0, "R4 all beats delivered", q_due.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule